// File: doc/BRIEF.md
# USB High-Speed Test Pattern Generator

This block sits inside a USB 2.0 high-speed controller and produces the compliance test patterns on the transmit side of a PHY-style interface. Software writes one byte to a test control register. The block then drives a continuous J, a continuous K, or a continuous SE0 on a two-bit line-state output. In SE0 mode it also answers every IN token with a NAK handshake. A fourth mode loops a preloaded 53-byte test packet out of a local buffer over a byte stream that uses valid and ready signals, with a fixed idle gap between copies.

The packet bytes are loaded through a byte-wide load port before the packet mode starts. Transmission begins on a transmit-ready strobe. If the buffer is not full when the strobe arrives, the block raises an underrun flag and stays idle. A host-select bit in the same register is passed to an output for the surrounding controller and does not change any pattern. No attached device is needed: the line patterns appear as soon as the register holds the test bit.

Top module: `hs_testpat_gen`

## Requirements
- R1: A write on `reg_wr_en` stores all 8 bits of `reg_wr_data` in the control register, and the new value takes effect on the outputs directly after the clock edge that stores it. With no test bit set, `line_state` is J and `tx_valid` is 0.
- R2: The `line_state` encoding is 2'b00 = SE0, 2'b01 = J, 2'b10 = K. The value 2'b11 never appears.
- R3: Bit 1 of the register gives a continuous J, and bit 2 gives a continuous K. Either pattern lasts for as long as the bit stays set.
- R4: Bit 0 selects SE0-with-NAK, which holds `line_state` at SE0. An `in_token` pulse in this mode presents the NAK PID 8'h5A on `tx_data`, with `tx_valid` high from the next cycle. It is held until `tx_ready`. `in_token` has no effect in any other mode.
- R5: When several test bits are set, the mode follows the priority bit 3 (packet), then bit 2 (K), then bit 1 (J), then bit 0 (SE0-with-NAK).
- R6: In packet mode (bit 3) with all 53 bytes loaded, a `tx_start` pulse starts transmission on the next cycle. The bytes go out in load order, one per cycle in which `tx_valid` and `tx_ready` are both high, and `tx_data` stays stable while `tx_ready` is low.
- R7: After the last byte, `tx_valid` stays low for exactly `GAP_BYTES` cycles (default 2, i.e. 16 bit times). The packet then repeats from byte 0.
- R8: A `tx_start` in packet mode with fewer than 53 bytes loaded sets `underrun_err`. No byte is sent and `line_state` stays J. The flag clears on the next register write.
- R9: Leaving packet mode drops `tx_valid` directly after the register write. The next start begins again at byte 0.
- R10: Bit 7 appears on `host_mode` and does not change `line_state` or the byte stream.
- R11: `tx_start` is ignored outside packet mode. Load writes after the 53rd byte are ignored and leave the stored bytes unchanged.
- R12: After reset the register is 0, the buffer is empty, `underrun_err` is 0, `line_state` is J and `tx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write byte |
| load_wr_en | input | 1 | Packet buffer load strobe |
| load_wr_data | input | 8 | Packet buffer load byte |
| tx_start | input | 1 | Transmit-packet-ready strobe |
| in_token | input | 1 | IN token received pulse |
| tx_ready | input | 1 | PHY accepts the current byte |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_data | output | 8 | Transmit byte |
| line_state | output | 2 | Driven line symbol (SE0/J/K) |
| host_mode | output | 1 | Host-select bit of the register |
| underrun_err | output | 1 | Packet start with buffer not full |

## Verification
The bench sweeps all 256 register values. The expected line symbol and host bit for each value are computed from the priority rule, which separates priority mistakes from encoding and decode-bit mistakes. The packet mode is run with a byte ramp that is distinct at every index, over two full repetitions. A ramp error points to an ordering or pointer fault, and a wrong idle-cycle count points to a gap fault. Separate runs cover a stall of several cycles, a start with a partly filled buffer, extra load writes, and leaving the mode in mid-packet. These show whether a fault lies in the handshake, the fill check or the pointer restart. A NAK run with ready held low and a token given in J mode separates the handshake path from the mode gating.

// File: rtl/hstp_pkg.sv
// Package: shared constants and types for the test pattern generator.
// Assumes a two-bit line symbol and an 8-bit control register.
package hstp_pkg;
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10
    } line_sym_t;

    typedef enum logic [2:0] {
        MODE_NONE,
        MODE_SE0NAK,
        MODE_J,
        MODE_K,
        MODE_PKT
    } tmode_t;

    localparam logic [7:0] NAK_PID = 8'h5A;

    localparam int BIT_SE0NAK = 0;
    localparam int BIT_J      = 1;
    localparam int BIT_K      = 2;
    localparam int BIT_PKT    = 3;
    localparam int BIT_HOST   = 7;
endpackage

// File: rtl/hstp_ctrl_reg.sv
// Control register and mode decode.
// Holds the byte written by software and turns it into one active test mode,
// highest priority first: packet, K, J, SE0-with-NAK.
// Assumes one full-byte write per strobe.
module hstp_ctrl_reg
    import hstp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] ctrl_q,
    output tmode_t     mode,
    output logic       host_sel
);
    // Purpose: store the control byte on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wr_data;
    end

    // Purpose: fixed-priority decode of the test bits.
    always_comb begin
        if (ctrl_q[BIT_PKT])
            mode = MODE_PKT;
        else if (ctrl_q[BIT_K])
            mode = MODE_K;
        else if (ctrl_q[BIT_J])
            mode = MODE_J;
        else if (ctrl_q[BIT_SE0NAK])
            mode = MODE_SE0NAK;
        else
            mode = MODE_NONE;
    end

    assign host_sel = ctrl_q[BIT_HOST];

    logic unused_hi;
    assign unused_hi = ^ctrl_q[6:4];
endmodule

// File: rtl/hstp_pkt_buf.sv
// Packet buffer: stores up to PKT_LEN bytes in load order.
// Loads after the buffer is full are dropped. Reads are asynchronous by index.
// Assumes the buffer is filled once after reset.
module hstp_pkt_buf #(
    parameter int PKT_LEN = 53,
    localparam int PTR_W  = $clog2(PKT_LEN),
    localparam int CNT_W  = $clog2(PKT_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [7:0]       rd_data,
    output logic             full
);
    logic [7:0]       mem [PKT_LEN];
    logic [CNT_W-1:0] fill_cnt;

    assign full = (fill_cnt == CNT_W'(PKT_LEN));

    // Purpose: count loaded bytes and stop at the packet length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_cnt <= '0;
        else if (wr_en && !full)
            fill_cnt <= fill_cnt + 1'b1;
    end

    // Purpose: write the next byte into the slot indexed by the count.
    always_ff @(posedge clk) begin
        if (wr_en && !full)
            mem[fill_cnt[PTR_W-1:0]] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/hstp_pkt_seq.sv
// Packet sequencer: on start, walks the buffer with a valid/ready handshake,
// inserts GAP_BYTES idle cycles after each packet and repeats.
// A start with a partly filled buffer sets the underrun flag instead.
// Assumes GAP_BYTES >= 1.
module hstp_pkt_seq #(
    parameter int PKT_LEN   = 53,
    parameter int GAP_BYTES = 2,
    localparam int PTR_W    = $clog2(PKT_LEN),
    localparam int GAP_W    = (GAP_BYTES > 1) ? $clog2(GAP_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic             buf_full,
    input  logic             ready,
    input  logic             err_clr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             valid,
    output logic             err
);
    typedef enum logic [1:0] {S_IDLE, S_SEND, S_GAP} seq_state_t;

    seq_state_t       state;
    logic [GAP_W-1:0] gap_cnt;

    localparam logic [PTR_W-1:0] LAST = PTR_W'(PKT_LEN - 1);

    // Purpose: step through idle, send and gap phases.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state   <= S_IDLE;
            rd_ptr  <= '0;
            gap_cnt <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    rd_ptr <= '0;
                    if (start && buf_full)
                        state <= S_SEND;
                end
                S_SEND: begin
                    if (ready) begin
                        if (rd_ptr == LAST) begin
                            rd_ptr  <= '0;
                            gap_cnt <= GAP_W'(GAP_BYTES - 1);
                            state   <= S_GAP;
                        end else begin
                            rd_ptr <= rd_ptr + 1'b1;
                        end
                    end
                end
                S_GAP: begin
                    if (gap_cnt == '0)
                        state <= S_SEND;
                    else
                        gap_cnt <= gap_cnt - 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Purpose: set the underrun flag on a premature start, clear on register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (enable && state == S_IDLE && start && !buf_full)
            err <= 1'b1;
        else if (err_clr)
            err <= 1'b0;
    end

    assign valid = enable && (state == S_SEND);
endmodule

// File: rtl/hs_testpat_gen.sv
// Top: USB high-speed test pattern generator.
// Combines the control register, packet buffer and sequencer, adds the NAK
// responder for SE0 mode and selects the line symbol and byte stream.
// Assumes in_token and tx_start are single-cycle pulses.
module hs_testpat_gen
    import hstp_pkg::*;
#(
    parameter int PKT_LEN   = 53,
    parameter int GAP_BYTES = 2,
    localparam int PTR_W    = $clog2(PKT_LEN)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_wr_data,
    input  logic       load_wr_en,
    input  logic [7:0] load_wr_data,
    input  logic       tx_start,
    input  logic       in_token,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic [1:0] line_state,
    output logic       host_mode,
    output logic       underrun_err
);
    logic [7:0]       ctrl_q;
    tmode_t           mode;
    logic [PTR_W-1:0] rd_ptr;
    logic [7:0]       buf_byte;
    logic             buf_full;
    logic             pkt_valid;
    logic             nak_pend;
    logic             pkt_en;
    logic             nak_en;

    hstp_ctrl_reg i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .ctrl_q   (ctrl_q),
        .mode     (mode),
        .host_sel (host_mode)
    );

    hstp_pkt_buf #(.PKT_LEN(PKT_LEN)) i_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (load_wr_en),
        .wr_data (load_wr_data),
        .rd_ptr  (rd_ptr),
        .rd_data (buf_byte),
        .full    (buf_full)
    );

    assign pkt_en = (mode == MODE_PKT);
    assign nak_en = (mode == MODE_SE0NAK);

    hstp_pkt_seq #(.PKT_LEN(PKT_LEN), .GAP_BYTES(GAP_BYTES)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (pkt_en),
        .start    (tx_start),
        .buf_full (buf_full),
        .ready    (tx_ready),
        .err_clr  (reg_wr_en),
        .rd_ptr   (rd_ptr),
        .valid    (pkt_valid),
        .err      (underrun_err)
    );

    // Purpose: hold a NAK request from an IN token until the PHY takes it.
    always_ff @(posedge clk) begin
        if (!rst_n || !nak_en)
            nak_pend <= 1'b0;
        else if (in_token)
            nak_pend <= 1'b1;
        else if (tx_ready)
            nak_pend <= 1'b0;
    end

    // Purpose: choose the byte stream source for the active mode.
    always_comb begin
        if (pkt_en) begin
            tx_valid = pkt_valid;
            tx_data  = buf_byte;
        end else begin
            tx_valid = nak_pend && nak_en;
            tx_data  = NAK_PID;
        end
    end

    // Purpose: map the active mode onto a line symbol, idle being J.
    always_comb begin
        case (mode)
            MODE_K:      line_state = LS_K;
            MODE_SE0NAK: line_state = LS_SE0;
            default:     line_state = LS_J;
        endcase
    end
endmodule

// File: rtl/hstp_checker.sv
// Checker: temporal properties of the test pattern generator, bound to the top.
module hstp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_en,
    input logic       in_token,
    input logic       tx_ready,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic [1:0] line_state,
    input logic       underrun_err,
    input logic [7:0] ctrl_q
);
    // R2: the unused symbol code never appears.
    assert_no_bad_symbol_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_state != 2'b11);

    // R3, R5: K wins over J and SE0 when packet mode is off.
    assert_k_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[2] && !ctrl_q[3]) |-> line_state == 2'b10);

    // R6: a byte not taken stays in place.
    assert_stall_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !reg_wr_en) |=> (tx_valid && $stable(tx_data)));

    // R8: an underrun keeps the stream silent and the line idle.
    assert_underrun_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_err |-> (!tx_valid && line_state == 2'b01));

    // R4: a token in SE0 mode yields a NAK on the next cycle.
    assert_nak_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_token && ctrl_q[3:0] == 4'b0001 && !reg_wr_en) |=>
            (tx_valid && tx_data == 8'h5A && line_state == 2'b00));
endmodule

bind hs_testpat_gen hstp_checker i_hstp_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .in_token     (in_token),
    .tx_ready     (tx_ready),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .line_state   (line_state),
    .underrun_err (underrun_err),
    .ctrl_q       (ctrl_q)
);

// File: tb/test_hs_testpat_gen.sv
// Bench: register sweep, NAK handshake, underrun, packet loop with gaps,
// stall, mid-packet exit and host bit, with arithmetic expected values.
module test_hs_testpat_gen;
    localparam int PKT_LEN   = 53;
    localparam int GAP_BYTES = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = '0;
    logic       load_wr_en = 1'b0;
    logic [7:0] load_wr_data = '0;
    logic       tx_start = 1'b0;
    logic       in_token = 1'b0;
    logic       tx_ready = 1'b1;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic [1:0] line_state;
    logic       host_mode;
    logic       underrun_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hs_testpat_gen #(.PKT_LEN(PKT_LEN), .GAP_BYTES(GAP_BYTES)) i_hs_testpat_gen (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .load_wr_en(load_wr_en), .load_wr_data(load_wr_data),
        .tx_start(tx_start), .in_token(in_token), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .line_state(line_state),
        .host_mode(host_mode), .underrun_err(underrun_err)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 7 + 3) & 8'hFF);
    endfunction

    // Expected symbol from the priority rule: SE0=0, J=1, K=2.
    function automatic logic [1:0] exp_sym(logic [7:0] v);
        if (v[3]) return 2'b01;
        if (v[2]) return 2'b10;
        if (v[1]) return 2'b01;
        if (v[0]) return 2'b00;
        return 2'b01;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(logic [7:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic load(logic [7:0] v);
        @(negedge clk);
        load_wr_en = 1'b1; load_wr_data = v;
        @(negedge clk);
        load_wr_en = 1'b0;
    endtask

    task automatic pulse_start;
        @(negedge clk);
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    // Checks one whole packet plus the gap, starting at a negedge showing byte 0.
    task automatic check_packet(string req);
        for (int k = 0; k < PKT_LEN; k++) begin
            chk(tx_valid == 1'b1 && tx_data == pat(k), req, "packet byte",
                {tx_valid, tx_data}, {1'b1, pat(k)});
            @(negedge clk);
        end
        for (int g = 0; g < GAP_BYTES; g++) begin
            chk(tx_valid == 1'b0, "R7", "gap idle", tx_valid, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(line_state == 2'b01, "R12", "reset line", line_state, 1);
        chk(tx_valid == 1'b0, "R12", "reset valid", tx_valid, 0);
        chk(underrun_err == 1'b0, "R12", "reset err", underrun_err, 0);
        chk(host_mode == 1'b0, "R12", "reset host", host_mode, 0);

        // R1, R2, R3, R5, R10: full register sweep
        for (int v = 0; v < 256; v++) begin
            wr_reg(8'(v));
            chk(line_state == exp_sym(8'(v)), "R5", "sweep line", line_state, exp_sym(8'(v)));
            chk(tx_valid == 1'b0, "R1", "sweep valid", tx_valid, 0);
            chk(host_mode == v[7], "R10", "sweep host", host_mode, v[7]);
        end

        // R4: NAK with ready low, held, then taken
        wr_reg(8'h01);
        tx_ready = 1'b0;
        @(negedge clk); in_token = 1'b1;
        @(negedge clk); in_token = 1'b0;
        chk(tx_valid && tx_data == 8'h5A, "R4", "nak out", tx_data, 8'h5A);
        chk(line_state == 2'b00, "R4", "se0 line", line_state, 0);
        @(negedge clk);
        chk(tx_valid && tx_data == 8'h5A, "R4", "nak hold", tx_data, 8'h5A);
        tx_ready = 1'b1;
        @(negedge clk);
        chk(tx_valid == 1'b0, "R4", "nak taken", tx_valid, 0);

        // R4, R11: token and start ignored in J mode
        wr_reg(8'h02);
        @(negedge clk); in_token = 1'b1; tx_start = 1'b1;
        @(negedge clk); in_token = 1'b0; tx_start = 1'b0;
        @(negedge clk);
        chk(tx_valid == 1'b0, "R11", "J mode ignores token/start", tx_valid, 0);
        chk(underrun_err == 1'b0, "R11", "no err outside packet", underrun_err, 0);

        // R8: underrun with a partial buffer
        for (int i = 0; i < 10; i++) load(pat(i));
        wr_reg(8'h08);
        pulse_start();
        chk(underrun_err == 1'b1, "R8", "err set", underrun_err, 1);
        chk(tx_valid == 1'b0, "R8", "no send", tx_valid, 0);
        chk(line_state == 2'b01, "R8", "line idle", line_state, 1);
        wr_reg(8'h08);
        chk(underrun_err == 1'b0, "R8", "err cleared", underrun_err, 0);

        // R11: complete the buffer plus extra writes that must be dropped
        for (int i = 10; i < PKT_LEN; i++) load(pat(i));
        for (int i = 0; i < 5; i++) load(8'hEE);

        // R6, R7, R11: two full repetitions
        pulse_start();
        chk(underrun_err == 1'b0, "R6", "no err when full", underrun_err, 0);
        check_packet("R6");
        check_packet("R7");

        // R6: stall at byte 4
        repeat (4) @(negedge clk);
        tx_ready = 1'b0;
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            chk(tx_valid && tx_data == pat(4), "R6", "stall hold", tx_data, pat(4));
        end
        tx_ready = 1'b1;
        @(negedge clk);
        chk(tx_valid && tx_data == pat(5), "R6", "after stall", tx_data, pat(5));

        // R9: leave mid-packet, re-enter starts at byte 0
        wr_reg(8'h00);
        chk(tx_valid == 1'b0, "R9", "exit valid", tx_valid, 0);
        chk(line_state == 2'b01, "R9", "exit line", line_state, 1);
        // R10: host bit with packet mode
        wr_reg(8'h88);
        chk(host_mode == 1'b1, "R10", "host set", host_mode, 1);
        pulse_start();
        check_packet("R9");
        chk(tx_valid && tx_data == pat(0), "R10", "repeat byte0 with host", tx_data, pat(0));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule